// File: doc/BRIEF.md
# Division-Free Prefetch Accuracy Threshold Comparator

This unit decides whether a prefetcher's accuracy has dropped below a chosen level. Accuracy is the fraction of issued prefetches that turned out useful. The unit takes two counts, useful and useless, and a code that selects a level between 10% and 90% in steps of 10%. It raises one flag when the accuracy lies strictly below that level. The surrounding logic can then throttle or reprioritise the prefetcher.

No divider or multiplier is used. For level k·10% the ratio test becomes `k·useless > (10−k)·useful`. Both coefficients are first divided by their common factor, leaving small constants in {1, 2, 3, 4, 7, 9}. Each constant is built from at most one shift plus one add or subtract.

All nine lanes are evaluated side by side, and the select code picks one result. A parameter chooses between a combinational flag and a flag registered on the clock. Registered is the default.

Top module: `acc_thr_cmp`

## Requirements
- R1: For select code k in 1..9 (level k·10%), the flag is 1 exactly when useful+useless > 0 and useful/(useful+useless) < k/10.
- R2: When the accuracy equals the selected level exactly (for example useful=3, useless=7 at code 3), the flag is 0.
- R3: When both counts are zero, the flag is 0 for every code.
- R4: Select codes 0 and 10..15 are invalid and give a flag of 0 whatever the counts.
- R5: A useless count of zero gives a flag of 0 at every code.
- R6: A useful count of zero with a nonzero useless count gives a flag of 1 at every valid code.
- R7: In the default registered variant, the flag shows the result for the inputs sampled at the previous rising clock edge. It holds its value between edges.
- R8: While active-low reset `rst_n` is 0, the registered flag is 0.
- R9: Counts across the full 8-bit range, up to 255 on both inputs, are judged correctly with no overflow in the scaled operands.
- R10: Code 5 (50%) reduces to a plain comparison: the flag is 1 exactly when useless > useful.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| useful_cnt | input | 8 | Count of prefetches that were used |
| useless_cnt | input | 8 | Count of prefetches evicted unused |
| thr_sel | input | 4 | Level code: k selects k·10% for k = 1..9; other codes are invalid |
| below_thr | output | 1 | 1 when accuracy is below the selected level |

## Verification
The clocked assertions assume the counts and the select code are stable and known at every rising edge outside reset, because each one compares the flag with the inputs sampled one edge earlier. The overflow guard assumes the operand width is at least four bits wider than the counts. The elaboration checks enforce this through the parameters. The bench changes inputs only on falling edges and keeps the default widths. It sweeps every select code, including all invalid ones, over a grid of counts in steps of five. That grid reaches 0, 255 and the exact tie points of every level.

// File: rtl/acc_thr_pkg.sv
`timescale 1ns/1ps
package acc_thr_pkg;

   // lowest and highest valid level code (code k means k*10 percent)
   localparam int unsigned LVL_MIN   = 1;
   localparam int unsigned LVL_MAX   = 9;
   localparam int unsigned LVL_STEPS = 10;

   function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
      int unsigned x;
      int unsigned y;
      int unsigned t;
      x = a;
      y = b;
      for (int i = 0; i < 16; i++) begin
         if (y != 0) begin
            t = x % y;
            x = y;
            y = t;
         end
      end
      return x;
   endfunction

   // reduced coefficient applied to the useless count
   function automatic int unsigned coef_useless(input int unsigned lvl);
      return lvl / gcd_u(lvl, LVL_STEPS - lvl);
   endfunction

   // reduced coefficient applied to the useful count
   function automatic int unsigned coef_useful(input int unsigned lvl);
      return (LVL_STEPS - lvl) / gcd_u(lvl, LVL_STEPS - lvl);
   endfunction

endpackage

// File: rtl/acc_thr_scale.sv
`timescale 1ns/1ps
module acc_thr_scale #(
   parameter int unsigned IN_W  = 8,
   parameter int unsigned OUT_W = 12,
   parameter int unsigned COEF  = 1
) (
   input  logic [IN_W-1:0]  x,
   output logic [OUT_W-1:0] y
);

   logic [OUT_W-1:0] xw;
   assign xw = OUT_W'(x);

   generate
      if (OUT_W < IN_W + 4) begin : g_bad_w
         $error("acc_thr_scale: OUT_W must be at least IN_W+4");
      end

      case (COEF)
         1: begin : g_c1
            assign y = xw;
         end
         2: begin : g_c2
            assign y = xw << 1;
         end
         3: begin : g_c3
            assign y = (xw << 1) + xw;
         end
         4: begin : g_c4
            assign y = xw << 2;
         end
         7: begin : g_c7
            assign y = (xw << 3) - xw;
         end
         9: begin : g_c9
            assign y = (xw << 3) + xw;
         end
         default: begin : g_cbad
            $error("acc_thr_scale: unsupported coefficient");
            assign y = '0;
         end
      endcase
   endgenerate

   // R9
   always_comb begin
      no_overflow_chk: assert (y >= xw);
   end

endmodule

// File: rtl/acc_thr_lane.sv
`timescale 1ns/1ps
module acc_thr_lane
   import acc_thr_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned OUT_W = 12,
   parameter int unsigned LEVEL = 5
) (
   input  logic [CNT_W-1:0] useful_cnt,
   input  logic [CNT_W-1:0] useless_cnt,
   output logic             lane_below
);

   localparam int unsigned C_NEG = coef_useless(LEVEL);
   localparam int unsigned C_POS = coef_useful(LEVEL);

   logic [OUT_W-1:0] neg_side;
   logic [OUT_W-1:0] pos_side;

   generate
      if (LEVEL < LVL_MIN || LEVEL > LVL_MAX) begin : g_bad_lvl
         $error("acc_thr_lane: LEVEL out of range");
      end
   endgenerate

   acc_thr_scale #(.IN_W(CNT_W), .OUT_W(OUT_W), .COEF(C_NEG)) u_neg (
      .x (useless_cnt),
      .y (neg_side)
   );

   acc_thr_scale #(.IN_W(CNT_W), .OUT_W(OUT_W), .COEF(C_POS)) u_pos (
      .x (useful_cnt),
      .y (pos_side)
   );

   // strict compare: a tie means accuracy equals the level, so not below
   assign lane_below = neg_side > pos_side;

endmodule

// File: rtl/acc_thr_cmp.sv
`timescale 1ns/1ps
module acc_thr_cmp
   import acc_thr_pkg::*;
#(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned SEL_W   = 4,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       useful_cnt,
   input  logic [7:0]       useless_cnt,
   input  logic [3:0]       thr_sel,
   output logic             below_thr
);

   localparam int unsigned OUT_W = CNT_W + 4;

   logic [LVL_MAX:LVL_MIN] lane_hit;
   logic                   hit_c;
   logic                   sel_ok;

   generate
      if (CNT_W != 8) begin : g_bad_cnt
         $error("acc_thr_cmp: port widths fix CNT_W at 8");
      end
      if (SEL_W != 4) begin : g_bad_sel
         $error("acc_thr_cmp: port widths fix SEL_W at 4");
      end

      for (genvar lv = LVL_MIN; lv <= LVL_MAX; lv++) begin : g_lane
         acc_thr_lane #(.CNT_W(CNT_W), .OUT_W(OUT_W), .LEVEL(lv)) u_lane (
            .useful_cnt  (useful_cnt),
            .useless_cnt (useless_cnt),
            .lane_below  (lane_hit[lv])
         );
      end
   endgenerate

   assign sel_ok = (thr_sel >= SEL_W'(LVL_MIN)) && (thr_sel <= SEL_W'(LVL_MAX));

   always_comb begin
      hit_c = 1'b0;
      for (int i = LVL_MIN; i <= LVL_MAX; i++) begin
         if (thr_sel == SEL_W'(i)) hit_c = lane_hit[i];
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) below_thr <= 1'b0;
            else        below_thr <= hit_c;
         end

         // R4
         bad_sel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_ok |=> !below_thr);

         // R3
         zero_counts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (useful_cnt == '0 && useless_cnt == '0) |=> !below_thr);

         // R5
         no_useless_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (useless_cnt == '0) |=> !below_thr);

         // R6
         no_useful_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_ok && useful_cnt == '0 && useless_cnt != '0) |=> below_thr);

         // R10
         half_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_sel == SEL_W'(5)) |=> (below_thr == $past(useless_cnt > useful_cnt)));
      end else begin : g_comb
         assign below_thr = hit_c;
      end
   endgenerate

endmodule

// File: tb/tb_acc_thr_cmp.sv
`timescale 1ns/1ps
module tb_acc_thr_cmp;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] useful_cnt = '0;
   logic [7:0] useless_cnt = '0;
   logic [3:0] thr_sel = '0;
   logic       below_thr;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   acc_thr_cmp dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .useful_cnt  (useful_cnt),
      .useless_cnt (useless_cnt),
      .thr_sel     (thr_sel),
      .below_thr   (below_thr)
   );

   function automatic bit ref_below(int u, int n, int k);
      if (k < 1 || k > 9) return 1'b0;
      if (u + n == 0) return 1'b0;
      return (10 * u) < (k * (u + n));
   endfunction

   task automatic check(string tag, bit act, bit exp, int u, int n, int k);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s u=%0d n=%0d sel=%0d actual=%0b expected=%0b", tag, u, n, k, act, exp);
      end
   endtask

   task automatic apply_and_check(int u, int n, int k);
      string tag;
      @(negedge clk);
      useful_cnt  = 8'(u);
      useless_cnt = 8'(n);
      thr_sel     = 4'(k);
      @(negedge clk);
      if (k < 1 || k > 9)              tag = "R4";
      else if (u == 0 && n == 0)       tag = "R3";
      else if (n == 0)                 tag = "R5";
      else if (u == 0)                 tag = "R6";
      else if (10 * u == k * (u + n))  tag = "R2";
      else if (u == 255 || n == 255)   tag = "R9";
      else if (k == 5)                 tag = "R10";
      else                             tag = "R1";
      check(tag, below_thr, ref_below(u, n, k), u, n, k);
   endtask

   initial begin
      #4_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // R8: flag low in reset even with inputs that would set it
      useful_cnt  = 8'd0;
      useless_cnt = 8'd10;
      thr_sel     = 4'd5;
      repeat (3) @(negedge clk);
      check("R8", below_thr, 1'b0, 0, 10, 5);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6", below_thr, 1'b1, 0, 10, 5);

      // R7: new inputs take effect only at the next rising edge
      useful_cnt  = 8'd10;
      useless_cnt = 8'd0;
      #5;
      check("R7", below_thr, 1'b1, 10, 0, 5);
      @(negedge clk);
      check("R7", below_thr, 1'b0, 10, 0, 5);

      // R2 ties at 30 and 70 percent, R9 extremes
      apply_and_check(3, 7, 3);
      apply_and_check(7, 3, 7);
      apply_and_check(255, 255, 5);
      apply_and_check(25, 230, 1);
      apply_and_check(24, 231, 1);

      // grid sweep over all codes
      for (int k = 0; k < 16; k++)
         for (int u = 0; u <= 255; u += 5)
            for (int n = 0; n <= 255; n += 5)
               apply_and_check(u, n, k);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule